// File: doc/BRIEF.md
# Dual-Width Timer/Counter with Input Capture

This block is a timer/counter that works in one of two widths. In narrow mode, one byte counts and two compare channels watch it, each on its own. In wide mode, a second byte carries the count to sixteen bits. The two compare bytes then join into one sixteen-bit compare value, and the second channel is gone. An optional auto-reload mode returns the count to zero on a compare match.

The counter steps on a clock-enable pulse from an outside prescaler. It can step instead on a chosen edge of an external count pin, which is first synchronised. An input capture unit watches one of two capture pins. The pin goes through a synchroniser, an optional noise filter and an edge detector. On the chosen edge, the unit copies the running count into a capture register.

Four event flags collect overflow, compare A, compare B and capture events. A mask selects which flags drive the registered interrupt line. Software reaches everything through a byte-wide register bus with registered read data. Sixteen-bit values go through a high-byte holding register, so software reads and writes them as one value.

Top module: `tdw_timer`

## Requirements
- R1: After synchronous reset, every register reads as zero and `irq` is low.
- R2: In narrow mode (CTRL bit0 = 0), each count tick raises the low count byte by one. The count wraps from 0xFF to 0x00 and sets flag bit0 (overflow). The high count byte does not change; a write to it only loads the holding register.
- R3: In wide mode (CTRL bit0 = 1), the low byte carries into the high byte. The count wraps from 0xFFFF to 0x0000 and sets flag bit0.
- R4: In narrow mode, a tick taken while the low byte equals CMPA sets flag bit1. A tick taken while the low byte equals CMPB sets flag bit2. The two compares act on their own.
- R5: In wide mode, a tick taken while the count equals {CMPB,CMPA} sets flag bit1. Flag bit2 is never set in wide mode.
- R6: With auto-reload on (CTRL bit1 = 1), a tick taken on a compare-A match returns the count to zero. In narrow mode only the low byte returns to zero. That tick does not set the overflow flag.
- R7: CTRL bit7 enables counting. With CTRL bit2 = 1, ticks come from edges of `ext_pin` and `presc_tick` is ignored. The edge is rising when CTRL bit3 = 0 and falling when it is 1.
- R8: CTRL bit4 selects `cap_pin[1]` or `cap_pin[0]`. CTRL bit5 selects the falling edge (1) or the rising edge (0). On that edge of the selected pin, the capture register takes the count and flag bit3 is set. In narrow mode the capture high byte is zero. The other pin and the other edge have no effect.
- R9: With the filter on (CTRL bit6 = 1), the filtered capture level changes only after FILT_LEN equal synchronised samples, so a shorter pulse triggers no capture. With the filter off, a two-clock pulse triggers a capture.
- R10: Flags are cleared by writing 1 to their bit in the FLAG register (bits 3:0). Writing 0 leaves a flag unchanged. Bits 7:4 of FLAG are the mask.
- R11: `irq` is high one clock after any flag bit is set together with its mask bit, and low one clock after no such pair remains.
- R12: In wide mode, a read of CNT_LO copies the high count byte into a holding register, and a read of CNT_HI returns that held value. A read of CAP_LO does the same for CAP_HI. A write to CNT_HI is held and applied together with the next CNT_LO write.
- R13: The register map is CTRL=0, CNT_LO=1, CNT_HI=2, CMPA=3, CMPB=4, CAP_LO=5, CAP_HI=6, FLAG=7. `bus_rdata` is valid on the clock after `bus_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Registered read data |
| presc_tick | input | 1 | Clock-enable pulse from the prescaler |
| ext_pin | input | 1 | External count pin (asynchronous) |
| cap_pin | input | 2 | Capture pins (asynchronous) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with BYTE_W = 8, FILT_LEN = 4 and SYNC_STAGES = 2. With eight-bit bytes, a narrow wrap takes at most 256 ticks. The sixteen-bit wrap and carry are reached by preloading the count near 0xFFFF or 0x12FF. The four-sample filter lets a two-clock glitch be rejected while an eight-clock pulse is accepted. Random trials pick width, auto-reload, compare values, start count and tick count, and compare the results against a per-tick model of the counter and flags.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int BYTE_W      = 8;
  localparam int NFLAG       = 4;

  localparam int A_CTRL = 0;
  localparam int A_CNTL = 1;
  localparam int A_CNTH = 2;
  localparam int A_CMPA = 3;
  localparam int A_CMPB = 4;
  localparam int A_CAPL = 5;
  localparam int A_CAPH = 6;
  localparam int A_FLAG = 7;

  localparam int FLG_OVF  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;
  localparam int FLG_CAP  = 3;

  typedef struct packed {
    logic run;       // bit7
    logic filt_en;   // bit6
    logic cap_fall;  // bit5
    logic cap_sel;   // bit4
    logic ext_fall;  // bit3
    logic ext_src;   // bit2
    logic auto_clr;  // bit1
    logic wide;      // bit0
  } ctrl_t;
endpackage

// File: rtl/tdw_input_cond.sv
module tdw_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic filt_en,
  input  logic fall_sel,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic synced, level, prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end
  assign synced = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 0) begin : g_filt
      logic [FILT_LEN-1:0] hist_q;
      logic                filt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          hist_q <= '0;
          filt_q <= 1'b0;
        end else begin
          hist_q <= {hist_q[FILT_LEN-2:0], synced};
          if (&hist_q)       filt_q <= 1'b1;
          else if (~|hist_q) filt_q <= 1'b0;
        end
      end
      assign level = filt_en ? filt_q : synced;
    end else begin : g_nofilt
      logic unused_filt;
      assign unused_filt = filt_en;
      assign level       = synced;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign edge_o = fall_sel ? (prev_q & ~level) : (~prev_q & level);
endmodule

// File: rtl/tdw_count_unit.sv
module tdw_count_unit #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  wide,
  input  logic                  auto_clr,
  input  logic [BYTE_W-1:0]     cmp_a,
  input  logic [BYTE_W-1:0]     cmp_b,
  input  logic                  ld_en,
  input  logic [2*BYTE_W-1:0]   ld_val,
  input  logic                  cap_evt,
  output logic [2*BYTE_W-1:0]   cnt_q,
  output logic [2*BYTE_W-1:0]   cap_q,
  output logic                  hit_ovf,
  output logic                  hit_a,
  output logic                  hit_b,
  output logic                  hit_cap
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic match_a, match_b, at_max, reload;

  assign cnt_q   = {hi_q, lo_q};
  assign match_a = wide ? (cnt_q == {cmp_b, cmp_a}) : (lo_q == cmp_a);
  assign match_b = ~wide & (lo_q == cmp_b);
  assign at_max  = wide ? (&cnt_q) : (&lo_q);
  assign reload  = auto_clr & match_a;

  assign hit_a   = tick & match_a;
  assign hit_b   = tick & match_b;
  assign hit_ovf = tick & at_max & ~reload;
  assign hit_cap = cap_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ld_en) begin
      lo_q <= ld_val[BYTE_W-1:0];
      hi_q <= ld_val[CNT_W-1:BYTE_W];
    end else if (tick) begin
      if (reload) begin
        lo_q <= '0;
        if (wide) hi_q <= '0;
      end else begin
        lo_q <= lo_q + 1'b1;
        if (wide && (&lo_q)) hi_q <= hi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_evt) cap_q <= wide ? cnt_q : {{BYTE_W{1'b0}}, lo_q};
  end
endmodule

// File: rtl/tdw_flag_unit.sv
module tdw_flag_unit #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [NFLAG-1:0] mask_d,
  output logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] mask_q,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_d;
      irq_q   <= |(flags_q & mask_q);
    end
  end
endmodule

// File: rtl/tdw_timer.sv
module tdw_timer
  import tdw_pkg::*;
#(
  parameter int BYTE_W      = tdw_pkg::BYTE_W,
  parameter int ADDR_W      = 3,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              presc_tick,
  input  logic              ext_pin,
  input  logic [1:0]        cap_pin,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] cmp_a_q, cmp_b_q, wr_hi_q, rd_hi_q;
  logic [CNT_W-1:0]  cnt_q, cap_q, ld_val;
  logic              ld_en, tick, ext_edge, cap_evt, cap_src;
  logic              hit_ovf, hit_a, hit_b, hit_cap;
  logic [NFLAG-1:0]  set_vec, clr_vec, flags_q, mask_q;
  logic              flag_wr;

  // input conditioning: external count pin (no filter) and capture pin
  tdw_input_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(0)) u_ext (
    .clk(clk), .rst(rst), .pin(ext_pin), .filt_en(1'b0),
    .fall_sel(ctrl_q.ext_fall), .edge_o(ext_edge));

  assign cap_src = ctrl_q.cap_sel ? cap_pin[1] : cap_pin[0];

  tdw_input_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cap (
    .clk(clk), .rst(rst), .pin(cap_src), .filt_en(ctrl_q.filt_en),
    .fall_sel(ctrl_q.cap_fall), .edge_o(cap_evt));

  assign tick = ctrl_q.run & (ctrl_q.ext_src ? ext_edge : presc_tick);

  // counter load from the bus, high byte via holding register in wide mode
  assign ld_en  = bus_we && (bus_addr == ADDR_W'(A_CNTL));
  assign ld_val = ctrl_q.wide ? {wr_hi_q, bus_wdata}
                              : {cnt_q[CNT_W-1:BYTE_W], bus_wdata};

  tdw_count_unit #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wide(ctrl_q.wide),
    .auto_clr(ctrl_q.auto_clr), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q),
    .ld_en(ld_en), .ld_val(ld_val), .cap_evt(cap_evt),
    .cnt_q(cnt_q), .cap_q(cap_q), .hit_ovf(hit_ovf), .hit_a(hit_a),
    .hit_b(hit_b), .hit_cap(hit_cap));

  // flags: set by events, cleared by writing ones
  assign flag_wr = bus_we && (bus_addr == ADDR_W'(A_FLAG));
  always_comb begin
    set_vec           = '0;
    set_vec[FLG_OVF]  = hit_ovf;
    set_vec[FLG_CMPA] = hit_a;
    set_vec[FLG_CMPB] = hit_b;
    set_vec[FLG_CAP]  = hit_cap;
    clr_vec           = flag_wr ? bus_wdata[NFLAG-1:0] : '0;
  end

  tdw_flag_unit #(.NFLAG(NFLAG)) u_flg (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(flag_wr), .mask_d(bus_wdata[2*NFLAG-1:NFLAG]),
    .flags_q(flags_q), .mask_q(mask_q), .irq_q(irq));

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      wr_hi_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        ADDR_W'(A_CTRL): ctrl_q  <= ctrl_t'(bus_wdata[7:0]);
        ADDR_W'(A_CNTH): wr_hi_q <= bus_wdata;
        ADDR_W'(A_CMPA): cmp_a_q <= bus_wdata;
        ADDR_W'(A_CMPB): cmp_b_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // registered reads with high-byte latching
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_hi_q   <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        ADDR_W'(A_CTRL): bus_rdata <= BYTE_W'(ctrl_q);
        ADDR_W'(A_CNTL): begin
          bus_rdata <= cnt_q[BYTE_W-1:0];
          if (ctrl_q.wide) rd_hi_q <= cnt_q[CNT_W-1:BYTE_W];
        end
        ADDR_W'(A_CNTH): bus_rdata <= ctrl_q.wide ? rd_hi_q : cnt_q[CNT_W-1:BYTE_W];
        ADDR_W'(A_CMPA): bus_rdata <= cmp_a_q;
        ADDR_W'(A_CMPB): bus_rdata <= cmp_b_q;
        ADDR_W'(A_CAPL): begin
          bus_rdata <= cap_q[BYTE_W-1:0];
          rd_hi_q   <= cap_q[CNT_W-1:BYTE_W];
        end
        ADDR_W'(A_CAPH): bus_rdata <= rd_hi_q;
        default:         bus_rdata <= BYTE_W'({mask_q, flags_q});
      endcase
    end
  end
endmodule

// File: rtl/tdw_checker.sv
module tdw_checker
  import tdw_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                ld_en,
  input logic                wide,
  input logic                auto_clr,
  input logic [BYTE_W-1:0]   cmp_a,
  input logic [BYTE_W-1:0]   cmp_b,
  input logic [2*BYTE_W-1:0] cnt,
  input logic [NFLAG-1:0]    flags,
  input logic [NFLAG-1:0]    mask,
  input logic                cap_evt,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [BYTE_W-1:0]   bus_wdata,
  input logic                irq
);
  logic cmp_hit, top_hit;
  assign cmp_hit = wide ? (cnt == {cmp_b, cmp_a}) : (cnt[BYTE_W-1:0] == cmp_a);
  assign top_hit = wide ? (&cnt) : (&cnt[BYTE_W-1:0]);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_en) |=> $stable(cnt));

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && top_hit && !(auto_clr && cmp_hit)) |=> flags[FLG_OVF]);

  assert_no_b_in_wide_R5: assert property (@(posedge clk) disable iff (rst)
    (wide && !flags[FLG_CMPB]) |=> !flags[FLG_CMPB]);

  assert_reload_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && auto_clr && cmp_hit) |=>
      ($past(wide) ? (cnt == '0) : (cnt[BYTE_W-1:0] == '0)));

  assert_capture_flag_R8: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flags[FLG_CAP]);

  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_clr
      assert_clear_by_write_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[gi]) |->
          $past(bus_we && (bus_addr == ADDR_W'(A_FLAG)) && bus_wdata[gi]));
    end
  endgenerate

  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (rst)
    (|(flags & mask)) |=> irq);

  assert_irq_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & mask)) |=> !irq);
endmodule

bind tdw_timer tdw_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ld_en(ld_en), .wide(ctrl_q.wide),
  .auto_clr(ctrl_q.auto_clr), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q),
  .cnt(cnt_q), .flags(flags_q), .mask(mask_q), .cap_evt(cap_evt),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq));

// File: tb/tdw_timer_tb.sv
module tdw_timer_tb;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          bus_we = 0, bus_re = 0;
  logic [2:0]    bus_addr = 0;
  logic [BW-1:0] bus_wdata = 0;
  logic [BW-1:0] bus_rdata;
  logic          presc_tick = 0, ext_pin = 0;
  logic [1:0]    cap_pin = 0;
  logic          irq;

  tdw_timer #(.BYTE_W(BW), .ADDR_W(3), .FILT_LEN(4), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_tick(presc_tick),
    .ext_pin(ext_pin), .cap_pin(cap_pin), .irq(irq));

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  // model state
  logic [15:0] m_cnt;
  logic [3:0]  m_flags;
  logic [3:0]  m_mask;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkctrl(input bit run, filt, cfall, csel,
                                        efall, esrc, aclr, wide);
    return {run, filt, cfall, csel, efall, esrc, aclr, wide};
  endfunction

  function automatic void mstep(input bit wide, input bit aclr, input logic [7:0] ca,
                                input logic [7:0] cb, inout logic [15:0] c,
                                inout logic [3:0] f);
    logic ma, mb, atmax, rl;
    ma    = wide ? (c == {cb, ca}) : (c[7:0] == ca);
    mb    = !wide && (c[7:0] == cb);
    atmax = wide ? (c == 16'hFFFF) : (c[7:0] == 8'hFF);
    rl    = aclr && ma;
    if (ma) f[1] = 1'b1;
    if (mb) f[2] = 1'b1;
    if (atmax && !rl) f[0] = 1'b1;
    if (rl) begin
      if (wide) c = 16'h0000; else c[7:0] = 8'h00;
    end else if (wide) c = c + 16'd1;
    else c[7:0] = c[7:0] + 8'd1;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_re = 1; bus_addr = a[2:0];
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n, input bit wide, input bit aclr,
                       input logic [7:0] ca, input logic [7:0] cb);
    @(negedge clk);
    presc_tick = 1;
    repeat (n) @(negedge clk);
    presc_tick = 0;
    for (int i = 0; i < n; i++) mstep(wide, aclr, ca, cb, m_cnt, m_flags);
  endtask

  task automatic set_cnt(input logic [15:0] v, input bit wide);
    wr(2, v[15:8]);
    wr(1, v[7:0]);
    m_cnt = wide ? v : {m_cnt[15:8], v[7:0]};
  endtask

  task automatic get_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(1, lo);
    rd(2, hi);
    v = {hi, lo};
  endtask

  task automatic clr_flags();
    wr(7, {m_mask, 4'hF});
    m_flags = 4'h0;
  endtask

  task automatic get_flags(output logic [3:0] f);
    logic [7:0] d;
    rd(7, d);
    f = d[3:0];
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v;
    logic [3:0]  f;
    void'($urandom(32'd4242));
    m_cnt = 0; m_flags = 0; m_mask = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset state of all registers and irq
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      check("R1 reset register", {24'd0, d}, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R13: map, control readback
    wr(0, 8'hA5);
    rd(0, d);
    check("R13 ctrl readback", {24'd0, d}, 32'hA5);
    wr(3, 8'h3C); rd(3, d);
    check("R13 cmpa readback", {24'd0, d}, 32'h3C);

    // R2: narrow wrap, high byte untouched
    wr(0, mkctrl(1,0,0,0,0,0,0,0));
    wr(3, 8'h00); wr(4, 8'h00);
    set_cnt(16'h5AFE, 1'b0);
    clr_flags();
    ticks(2, 0, 0, 8'h00, 8'h00);
    get_cnt(v); get_flags(f);
    check("R2 narrow wrap count", {16'd0, v}, {16'd0, m_cnt});
    check("R2 narrow wrap high byte", {24'd0, v[15:8]}, 32'h00);
    check("R2 narrow overflow flag", {31'd0, f[0]}, 32'd1);

    // R3: wide carry and wrap
    wr(0, mkctrl(1,0,0,0,0,0,0,1));
    wr(3, 8'h34); wr(4, 8'h12);
    set_cnt(16'h12FF, 1'b1);
    clr_flags();
    ticks(1, 1, 0, 8'h34, 8'h12);
    get_cnt(v);
    check("R3 wide carry", {16'd0, v}, 32'h1300);
    set_cnt(16'hFFFE, 1'b1);
    ticks(2, 1, 0, 8'h34, 8'h12);
    get_cnt(v); get_flags(f);
    check("R3 wide wrap", {16'd0, v}, 32'h0000);
    check("R3 wide overflow flag", {28'd0, f}, {28'd0, m_flags});

    // R4: narrow independent compares
    wr(0, mkctrl(1,0,0,0,0,0,0,0));
    wr(3, 8'h10); wr(4, 8'h20);
    set_cnt(16'h000F, 1'b0);
    clr_flags();
    ticks(2, 0, 0, 8'h10, 8'h20);
    get_flags(f);
    check("R4 compare A only", {28'd0, f}, 32'h2);
    ticks(16, 0, 0, 8'h10, 8'h20);
    get_flags(f);
    check("R4 compare B also", {28'd0, f}, 32'h6);

    // R5: wide single compare, no B flag
    wr(0, mkctrl(1,0,0,0,0,0,0,1));
    set_cnt(16'h1F1E, 1'b1);
    clr_flags();
    ticks(3, 1, 0, 8'h10, 8'h20);
    get_flags(f);
    check("R5 wide no B flag", {28'd0, f}, 32'h0);
    set_cnt(16'h200F, 1'b1);
    ticks(2, 1, 0, 8'h10, 8'h20);
    get_flags(f);
    check("R5 wide joined compare", {28'd0, f}, 32'h2);

    // R6: auto-reload narrow, incl. compare at 0xFF
    wr(0, mkctrl(1,0,0,0,0,0,1,0));
    wr(3, 8'h05);
    set_cnt(16'h0000, 1'b0);
    clr_flags();
    ticks(6, 0, 1, 8'h05, 8'h20);
    get_cnt(v); get_flags(f);
    check("R6 narrow reload", {24'd0, v[7:0]}, 32'h00);
    check("R6 narrow reload flags", {28'd0, f}, 32'h2);
    wr(3, 8'hFF);
    set_cnt(16'h00FE, 1'b0);
    clr_flags();
    ticks(2, 0, 1, 8'hFF, 8'h20);
    get_flags(f);
    check("R6 reload at max no overflow", {28'd0, f}, 32'h2);
    wr(0, mkctrl(1,0,0,0,0,0,1,1));
    wr(3, 8'h02); wr(4, 8'h01);
    set_cnt(16'h0100, 1'b1);
    ticks(5, 1, 1, 8'h02, 8'h01);
    get_cnt(v);
    check("R6 wide reload", {16'd0, v}, {16'd0, m_cnt});

    // R7: run disabled
    wr(0, mkctrl(0,0,0,0,0,0,0,0));
    set_cnt(16'h0040, 1'b0);
    wait_cyc(1); presc_tick = 1; wait_cyc(5); presc_tick = 0;
    get_cnt(v);
    check("R7 no count when stopped", {24'd0, v[7:0]}, 32'h40);
    // R7: external rising edges, prescaler ignored
    wr(0, mkctrl(1,0,0,0,0,1,0,0));
    presc_tick = 1;
    for (int i = 0; i < 4; i++) begin
      ext_pin = 1; wait_cyc(3); ext_pin = 0; wait_cyc(3);
    end
    wait_cyc(5); presc_tick = 0;
    get_cnt(v);
    check("R7 external rising count", {24'd0, v[7:0]}, 32'h44);
    wr(0, mkctrl(1,0,0,0,1,1,0,0));
    for (int i = 0; i < 3; i++) begin
      ext_pin = 1; wait_cyc(3); ext_pin = 0; wait_cyc(3);
    end
    wait_cyc(5);
    get_cnt(v);
    check("R7 external falling count", {24'd0, v[7:0]}, 32'h47);

    // R8: capture on falling edge of pin 1, wide
    wr(0, mkctrl(0,0,1,1,0,0,0,1));
    set_cnt(16'h1234, 1'b1);
    clr_flags();
    cap_pin[1] = 1; wait_cyc(10);
    get_flags(f);
    check("R8 wrong edge ignored", {31'd0, f[3]}, 32'd0);
    cap_pin[1] = 0; wait_cyc(10);
    get_flags(f);
    check("R8 capture flag", {31'd0, f[3]}, 32'd1);
    rd(5, d); v[7:0] = d; rd(6, d); v[15:8] = d;
    check("R8 captured value", {16'd0, v}, 32'h1234);
    clr_flags();
    cap_pin[0] = 1; wait_cyc(8); cap_pin[0] = 0; wait_cyc(8);
    get_flags(f);
    check("R8 unselected pin ignored", {31'd0, f[3]}, 32'd0);
    // narrow capture high byte zero
    wr(0, mkctrl(0,0,0,0,0,0,0,0));
    set_cnt(16'h0077, 1'b0);
    cap_pin[0] = 1; wait_cyc(8); cap_pin[0] = 0; wait_cyc(4);
    rd(5, d); v[7:0] = d; rd(6, d); v[15:8] = d;
    check("R8 narrow capture", {16'd0, v}, {16'd0, m_cnt[15:8] & 8'h00, 8'h77});

    // R9: filter rejects short glitch, accepts long pulse
    wr(0, mkctrl(0,1,0,0,0,0,0,0));
    clr_flags();
    cap_pin[0] = 1; wait_cyc(2); cap_pin[0] = 0; wait_cyc(12);
    get_flags(f);
    check("R9 filtered glitch ignored", {31'd0, f[3]}, 32'd0);
    cap_pin[0] = 1; wait_cyc(8); cap_pin[0] = 0; wait_cyc(12);
    get_flags(f);
    check("R9 filtered pulse taken", {31'd0, f[3]}, 32'd1);
    wr(0, mkctrl(0,0,0,0,0,0,0,0));
    clr_flags();
    cap_pin[0] = 1; wait_cyc(2); cap_pin[0] = 0; wait_cyc(8);
    get_flags(f);
    check("R9 unfiltered glitch taken", {31'd0, f[3]}, 32'd1);

    // R10: write-one-to-clear
    wr(0, mkctrl(1,0,0,0,0,0,0,0));
    wr(3, 8'h01); wr(4, 8'h02);
    set_cnt(16'h00FF, 1'b0);
    clr_flags();
    ticks(4, 0, 0, 8'h01, 8'h02);
    wr(7, 8'h00);
    get_flags(f);
    check("R10 zero write keeps flags", {28'd0, f}, {28'd0, m_flags});
    wr(7, 8'h01);
    m_flags[0] = 1'b0;
    get_flags(f);
    check("R10 clear bit0 only", {28'd0, f}, {28'd0, m_flags});

    // R11: irq masking
    check("R11 irq low while unmasked", {31'd0, irq}, 32'd0);
    m_mask = 4'h2;
    wr(7, {m_mask, 4'h0});
    wait_cyc(2);
    check("R11 irq high when masked flag set", {31'd0, irq}, 32'd1);
    wr(7, {m_mask, 4'h2});
    m_flags[1] = 1'b0;
    wait_cyc(2);
    check("R11 irq low after clear", {31'd0, irq}, 32'd0);
    m_mask = 4'h0;
    wr(7, 8'h0F);
    m_flags = 0;

    // R12: atomic wide read
    wr(0, mkctrl(1,0,0,0,0,0,0,1));
    wr(3, 8'h00); wr(4, 8'h00);
    set_cnt(16'h12FF, 1'b1);
    rd(1, d);
    check("R12 low byte", {24'd0, d}, 32'hFF);
    ticks(1, 1, 0, 8'h00, 8'h00);
    rd(2, d);
    check("R12 latched high byte", {24'd0, d}, 32'h12);
    get_cnt(v);
    check("R12 fresh wide read", {16'd0, v}, 32'h1300);

    // random trials against the model (R2..R6)
    for (int t = 0; t < 40; t++) begin
      bit         w, ac;
      logic [7:0] ca, cb;
      logic [15:0] st;
      int         n;
      w  = 1'($urandom % 2);
      ac = 1'($urandom % 2);
      ca = 8'($urandom);
      cb = 8'($urandom);
      n  = 1 + ($urandom % 300);
      if (w) st = {cb, ca} - 16'($urandom % 200);
      else   st = 16'($urandom);
      if (w && ($urandom % 3 == 0)) st = 16'hFFFF - 16'($urandom % 100);
      wr(0, mkctrl(1,0,0,0,0,0,ac,w));
      wr(3, ca); wr(4, cb);
      set_cnt(st, w);
      clr_flags();
      ticks(n, w, ac, ca, cb);
      get_cnt(v); get_flags(f);
      if (w) check("R3 R5 R6 random wide count", {16'd0, v}, {16'd0, m_cnt});
      else   check("R2 R4 R6 random narrow count", {24'd0, v[7:0]}, {24'd0, m_cnt[7:0]});
      check("R4 R5 random flags", {28'd0, f}, {28'd0, m_flags});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule